// File: doc/BRIEF.md
# Two-Channel Serial Event Interrupt Collector

This block gathers the ready indications of two serial channels into one shared event byte, gates that byte with a software-loaded enable mask, and drives a single active-low interrupt request to the host. Each channel owns a four-bit nibble of the byte. Within that nibble, bit 0 is transmit-ready and bit 1 is receive-ready. Bits 2 and 3 of each nibble are held for counter and input-change events that this block does not produce.

The host reaches the block at one global register address, which is the same for every channel. A read at that address returns the event byte, and a write at that address loads the mask. The event bits are live copies of the source levels. Software stops transmit interrupts by clearing that channel's transmit-ready mask bit once its transmitter is idle.

Top module: `dual_irq_status`

## Requirements
- R1: The event byte places channel n's transmit-ready level at bit 4n and its receive-ready level at bit 4n+1. All other bits read as zero, and setting their mask bits never causes a request.
- R2: A read strobe at address 5 loads `bus_rdata` with the event byte on the next clock edge. A read at any other address loads zero. `bus_rdata` holds its value when there is no read strobe.
- R3: A write strobe at address 5 loads the mask from `bus_wdata` on the clock edge. Writes at any other address leave the mask unchanged.
- R4: `irq_n` goes low on the first clock edge after any bit of (event byte AND mask) is set.
- R5: `irq_n` returns high on the first clock edge after no bit of (event byte AND mask) remains set. This applies whether the source fell or its mask bit was cleared.
- R6: After reset the mask is zero, `irq_n` is high and `bus_rdata` is zero. No source can request an interrupt until the mask is written.
- R7: Reading the event byte does not clear any event bit or the request.
- R8: Clearing one channel's transmit-ready mask bit removes that source's request. Other unmasked sources keep `irq_n` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_ready | input | 2 | Per-channel transmit-ready level |
| rx_ready | input | 2 | Per-channel receive-ready level |
| bus_addr | input | 4 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data (mask) |
| bus_rdata | output | 8 | Read data, registered |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A change of a source level is seen on `irq_n` one clock edge later. A mask write takes effect at its own edge, so the request moves one edge after that, two edges after the write was driven. Read data appears at the edge that samples the read strobe. The bench drives all inputs at the falling edge and samples 1 ns after the rising edge on which each result is due. For mask writes it checks both the edge where the request must not yet move and the edge where it must.

// File: rtl/dual_irq_status.sv
module dual_irq_status #(
  parameter int NUM_CH      = 2,
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int STATUS_ADDR = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] tx_ready,
  input  logic [NUM_CH-1:0] rx_ready,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_n
);
  localparam logic [ADDR_W-1:0] SEL = STATUS_ADDR[ADDR_W-1:0];

  logic [DATA_W-1:0] status;
  logic [DATA_W-1:0] mask;
  logic              hit;
  logic              pending;

  always_comb begin
    status = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      status[4*n]     = tx_ready[n];
      status[4*n + 1] = rx_ready[n];
    end
  end

  assign hit     = (bus_addr == SEL);
  assign pending = |(status & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask      <= '0;
      bus_rdata <= '0;
      irq_n     <= 1'b1;
    end else begin
      if (bus_wr && hit) mask <= bus_wdata;
      if (bus_rd) bus_rdata <= hit ? status : '0;
      irq_n <= ~pending;
    end
  end

  a_r4_request: assert property (@(posedge clk) disable iff (!rst_n)
    pending |=> !irq_n);

  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |=> irq_n);

  a_r3_mask_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && hit) |=> $stable(mask));

  a_r2_read_data: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && hit) |=> bus_rdata == $past(status));

  a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/tb_dual_irq_status.sv
module tb_dual_irq_status;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [1:0] tx_ready = 0, rx_ready = 0;
  logic [3:0] bus_addr = 0;
  logic       bus_rd = 0, bus_wr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic       irq_n;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  dual_irq_status dut (.clk(clk), .rst_n(rst_n), .tx_ready(tx_ready), .rx_ready(rx_ready),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_n(irq_n));

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic set_src(logic [1:0] tx, logic [1:0] rx);
    @(negedge clk); tx_ready = tx; rx_ready = rx;
    tick();
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    tick(); d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    tick();
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R6 irq_n after reset", {7'b0, irq_n}, 8'h01);
    chk("R6 rdata after reset", bus_rdata, 8'h00);
    set_src(2'b11, 2'b11);
    tick();
    chk("R6 no request with zero mask", {7'b0, irq_n}, 8'h01);
    set_src(2'b00, 2'b00);
    rd(4'd5, d);
    chk("R2 idle status", d, 8'h00);
  endtask

  task automatic t_bitmap();
    logic [7:0] d;
    set_src(2'b01, 2'b00); rd(4'd5, d); chk("R1 tx0 bit0", d, 8'h01);
    set_src(2'b00, 2'b01); rd(4'd5, d); chk("R1 rx0 bit1", d, 8'h02);
    set_src(2'b10, 2'b00); rd(4'd5, d); chk("R1 tx1 bit4", d, 8'h10);
    set_src(2'b00, 2'b10); rd(4'd5, d); chk("R1 rx1 bit5", d, 8'h20);
    set_src(2'b11, 2'b11); rd(4'd5, d); chk("R1 all sources", d, 8'h33);
    rd(4'd4, d); chk("R2 other address reads zero", d, 8'h00);
    @(negedge clk); #1;
    chk("R2 rdata held without strobe", bus_rdata, 8'h00);
    wr(4'd5, 8'hCC); tick();
    chk("R1 reserved mask bits no request", {7'b0, irq_n}, 8'h01);
    wr(4'd5, 8'h00);
    set_src(2'b00, 2'b00);
  endtask

  task automatic t_request();
    logic [7:0] d;
    wr(4'd5, 8'h02);
    @(negedge clk); rx_ready = 2'b01;
    #1 chk("R4 not before edge", {7'b0, irq_n}, 8'h01);
    tick();
    chk("R4 request one edge after source", {7'b0, irq_n}, 8'h00);
    rd(4'd5, d); chk("R7 first read", d, 8'h02);
    rd(4'd5, d); chk("R7 second read unchanged", d, 8'h02);
    chk("R7 request kept after reads", {7'b0, irq_n}, 8'h00);
    set_src(2'b00, 2'b00);
    chk("R5 release one edge after source falls", {7'b0, irq_n}, 8'h01);
  endtask

  task automatic t_mask_clear();
    set_src(2'b10, 2'b00);
    wr(4'd5, 8'h10);
    chk("R3 mask takes effect at write edge", {7'b0, irq_n}, 8'h01);
    tick();
    chk("R4 request after mask write", {7'b0, irq_n}, 8'h00);
    wr(4'd4, 8'h00); tick();
    chk("R3 write elsewhere ignored", {7'b0, irq_n}, 8'h00);
    wr(4'd5, 8'h00);
    chk("R5 still low at mask write edge", {7'b0, irq_n}, 8'h00);
    tick();
    chk("R5 release after masking", {7'b0, irq_n}, 8'h01);
    set_src(2'b00, 2'b00);
  endtask

  task automatic t_tx_stop();
    set_src(2'b01, 2'b01);
    wr(4'd5, 8'h03); tick();
    chk("R8 both sources request", {7'b0, irq_n}, 8'h00);
    wr(4'd5, 8'h02); tick(); tick();
    chk("R8 rx keeps request after tx masked", {7'b0, irq_n}, 8'h00);
    set_src(2'b01, 2'b00);
    chk("R8 tx masked alone no request", {7'b0, irq_n}, 8'h01);
    set_src(2'b00, 2'b00);
  endtask

  initial begin
    #20 rst_n = 1;
    tick();
    t_reset();
    t_bitmap();
    t_request();
    t_mask_clear();
    t_tx_stop();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule